// File: doc/BRIEF.md
# OTG Event Interrupt Latch

This block watches a set of single-bit OTG status lines (VBUS valid, session valid, session end, ID ground) plus a separate B-valid line. Each line is brought into the clock domain by a synchronizer. It is then compared with its previous value. Every source has its own enable for upward changes and its own enable for downward changes. An enabled change sets that source's bit in an event latch and asks the bus controller to send a receive-command byte to the link.

The latch empties itself when the link reads it, and when the PHY goes into low-power mode. The B-valid line has one control of its own: a downward-change enable. When that enable is set and B-valid drops, the block raises a receive-command request with an alternate-interrupt flag. This path does not touch the latch.

Software reaches the enables through a small register port that can write, OR-set or AND-clear a register. The same port reads back the latch and the synchronized line levels.

Top module: `otg_evt_irq`

## Requirements
- R1: After reset the rise-enable, fall-enable and alt-enable registers are 0, the latch is 0, and the request and alt flag are low. Edge detection starts only once the synchronizer pipeline holds sampled values.
- R2: When a source goes 0 to 1 and its bit in the rise-enable register (address 0) is 1, that bit of the latch (address 2) becomes 1.
- R3: When a source goes 1 to 0 and its bit in the fall-enable register (address 1) is 1, that bit of the latch becomes 1.
- R4: A change whose enable bit is 0 leaves the latch unchanged and raises no request.
- R5: Reading address 2 returns the latch value held before the read edge and clears every latch bit.
- R6: A latch bit set by an event on the same edge as a latch read stays 1 after that read. The read itself returns the old value.
- R7: A 0 to 1 change on the low-power input clears every latch bit on the next edge.
- R8: Register operation codes are 00 write, 01 set (OR), 10 clear (AND-NOT) and 11 no effect. Addresses are 0 rise enable, 1 fall enable, 2 latch (writes have no effect), 3 alt enable in bit 0, and 4 synchronized source levels. Read data appears one edge after the read strobe.
- R9: Any enabled event raises the receive-command request. The request stays high until an acknowledge, and events arriving while it is pending merge into that single request.
- R10: When alt enable is 1 and B-valid goes 1 to 0, the request and the alt flag rise together. An acknowledge drops both.
- R11: A B-valid rise, or a B-valid fall while alt enable is 0, raises no request.
- R12: An event on the same edge as an acknowledge keeps the request high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Asynchronous OTG status lines |
| bvalid_i | input | 1 | Asynchronous B-valid line |
| lpm_i | input | 1 | PHY low-power mode level |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_op_i | input | 2 | Write operation: 00 write, 01 set, 10 clear, 11 none |
| reg_wdata_i | input | N_SRC | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | N_SRC | Registered read data |
| rxcmd_req_o | output | 1 | Receive-command request to the bus controller |
| rxcmd_alt_o | output | 1 | Alternate-interrupt flag for the pending request |
| rxcmd_ack_i | input | 1 | Request acknowledge |

## Verification
A source change driven between edges reaches the latch and the request on the third rising edge after it is driven: two synchronizer stages, then the edge register. Reads, acknowledges and low-power entry each take effect on the first edge after they are driven.

The bench drives every input on a falling edge and waits exactly those edge counts before it samples on the next falling edge. The two same-edge cases (a read with an event, and an acknowledge with an event) are built by starting the read or acknowledge two edges after the source change, so that both land on the third edge.

// File: rtl/otg_evt_pkg.sv
package otg_evt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_RISE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FALL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LATCH = 3'd2;
  localparam logic [ADDR_W-1:0] A_ALT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_SET   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_NONE  = 2'b11
  } reg_op_e;
endpackage

// File: rtl/otg_evt_sync.sv
module otg_evt_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/otg_evt_edge.sv
module otg_evt_edge #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         armed_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic up, dn;
    assign up = lvl_i[i] & ~prev_q[i];
    assign dn = ~lvl_i[i] & prev_q[i];
    assign evt_o[i] = armed_i & ((rise_en_i[i] & up) | (fall_en_i[i] & dn));
  end
endmodule

// File: rtl/otg_evt_regs.sv
module otg_evt_regs
  import otg_evt_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [1:0]        op_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic              rd_i,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              lpm_entry_i,
  input  logic [N_SRC-1:0]  lvl_i,
  output logic [N_SRC-1:0]  rise_en_o,
  output logic [N_SRC-1:0]  fall_en_o,
  output logic              alt_en_o,
  output logic [N_SRC-1:0]  latch_o,
  output logic [N_SRC-1:0]  rdata_o
);
  logic [N_SRC-1:0] rise_q, fall_q, latch_q, rdata_q;
  logic             alt_q, alt_nx, latch_clr;
  logic [N_SRC-1:0] rise_nx, fall_nx, latch_nx, rd_mux;

  function automatic logic [N_SRC-1:0] apply_op(logic [N_SRC-1:0] cur,
                                                logic [1:0] op,
                                                logic [N_SRC-1:0] d);
    case (reg_op_e'(op))
      OP_WRITE: apply_op = d;
      OP_SET:   apply_op = cur | d;
      OP_CLEAR: apply_op = cur & ~d;
      default:  apply_op = cur;
    endcase
  endfunction

  always_comb begin
    rise_nx = rise_q;
    fall_nx = fall_q;
    alt_nx  = alt_q;
    if (wr_i) begin
      if (addr_i == A_RISE) rise_nx = apply_op(rise_q, op_i, wdata_i);
      if (addr_i == A_FALL) fall_nx = apply_op(fall_q, op_i, wdata_i);
      if (addr_i == A_ALT) begin
        case (reg_op_e'(op_i))
          OP_WRITE: alt_nx = wdata_i[0];
          OP_SET:   alt_nx = alt_q | wdata_i[0];
          OP_CLEAR: alt_nx = alt_q & ~wdata_i[0];
          default:  alt_nx = alt_q;
        endcase
      end
    end
  end

  // clear first, then merge same-edge events
  assign latch_clr = lpm_entry_i | (rd_i & (addr_i == A_LATCH));
  assign latch_nx  = (latch_clr ? '0 : latch_q) | evt_i;

  always_comb begin
    case (addr_i)
      A_RISE:  rd_mux = rise_q;
      A_FALL:  rd_mux = fall_q;
      A_LATCH: rd_mux = latch_q;
      A_ALT:   rd_mux = {{(N_SRC-1){1'b0}}, alt_q};
      A_STAT:  rd_mux = lvl_i;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q  <= '0;
      fall_q  <= '0;
      alt_q   <= 1'b0;
      latch_q <= '0;
      rdata_q <= '0;
    end else begin
      rise_q  <= rise_nx;
      fall_q  <= fall_nx;
      alt_q   <= alt_nx;
      latch_q <= latch_nx;
      if (rd_i) rdata_q <= rd_mux;
    end
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign alt_en_o  = alt_q;
  assign latch_o   = latch_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/otg_evt_rxreq.sv
module otg_evt_rxreq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic alt_evt_i,
  input  logic ack_i,
  output logic req_o,
  output logic alt_o
);
  logic req_q, alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      alt_q <= 1'b0;
    end else begin
      req_q <= evt_i | alt_evt_i | (req_q & ~ack_i);
      alt_q <= alt_evt_i | (alt_q & ~ack_i);
    end
  end

  assign req_o = req_q;
  assign alt_o = alt_q;
endmodule

// File: rtl/otg_evt_irq.sv
module otg_evt_irq
  import otg_evt_pkg::*;
#(
  parameter int N_SRC       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bvalid_i,
  input  logic              lpm_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_op_i,
  input  logic [N_SRC-1:0]  reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [N_SRC-1:0]  reg_rdata_o,
  output logic              rxcmd_req_o,
  output logic              rxcmd_alt_o,
  input  logic              rxcmd_ack_i
);
  localparam int ARM_LEN = SYNC_STAGES + 1;

  logic [N_SRC:0]   lvl_all;
  logic [N_SRC-1:0] src_lvl, src_evt, rise_en, fall_en, latch_w;
  logic             bv_lvl, alt_evt, alt_en, lpm_q, lpm_entry, armed;
  logic [ARM_LEN-1:0] arm_q;

  otg_evt_sync #(.W(N_SRC+1), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({bvalid_i, src_i}), .q_o(lvl_all)
  );
  assign src_lvl = lvl_all[N_SRC-1:0];
  assign bv_lvl  = lvl_all[N_SRC];

  // hold off edges until pipeline and edge register carry real samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= '0;
      lpm_q <= 1'b0;
    end else begin
      arm_q <= {arm_q[ARM_LEN-2:0], 1'b1};
      lpm_q <= lpm_i;
    end
  end
  assign armed     = arm_q[ARM_LEN-1];
  assign lpm_entry = lpm_i & ~lpm_q;

  otg_evt_edge #(.W(N_SRC)) u_edge (
    .clk_i, .rst_ni, .armed_i(armed), .lvl_i(src_lvl),
    .rise_en_i(rise_en), .fall_en_i(fall_en), .evt_o(src_evt)
  );

  otg_evt_edge #(.W(1)) u_alt_edge (
    .clk_i, .rst_ni, .armed_i(armed), .lvl_i(bv_lvl),
    .rise_en_i(1'b0), .fall_en_i(alt_en), .evt_o(alt_evt)
  );

  otg_evt_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i, .rst_ni, .addr_i(reg_addr_i), .wr_i(reg_wr_i), .op_i(reg_op_i),
    .wdata_i(reg_wdata_i), .rd_i(reg_rd_i), .evt_i(src_evt),
    .lpm_entry_i(lpm_entry), .lvl_i(src_lvl), .rise_en_o(rise_en),
    .fall_en_o(fall_en), .alt_en_o(alt_en), .latch_o(latch_w),
    .rdata_o(reg_rdata_o)
  );

  otg_evt_rxreq u_req (
    .clk_i, .rst_ni, .evt_i(|src_evt), .alt_evt_i(alt_evt),
    .ack_i(rxcmd_ack_i), .req_o(rxcmd_req_o), .alt_o(rxcmd_alt_o)
  );
endmodule

// File: rtl/otg_evt_irq_chk.sv
module otg_evt_irq_chk #(
  parameter int N_SRC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lpm_i,
  input logic             reg_rd_i,
  input logic [2:0]       reg_addr_i,
  input logic             rxcmd_req_o,
  input logic             rxcmd_alt_o,
  input logic             rxcmd_ack_i,
  input logic [N_SRC-1:0] evt,
  input logic             alt_evt,
  input logic [N_SRC-1:0] latch
);
  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 3'd2 && evt == '0) |=> latch == '0);

  a_r7_lpm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lpm_i) && evt == '0) |=> latch == '0);

  a_r6_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt) |=> ((latch & $past(evt)) == $past(evt)));

  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxcmd_req_o && !rxcmd_ack_i) |=> rxcmd_req_o);

  a_r12_evt_raises_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|evt) || alt_evt) |=> rxcmd_req_o);

  a_r10_alt_evt_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_evt |=> (rxcmd_alt_o && rxcmd_req_o));

  a_r10_alt_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxcmd_alt_o |-> rxcmd_req_o);

  a_r4_no_spurious_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rxcmd_req_o && evt == '0 && !alt_evt) |=> !rxcmd_req_o);
endmodule

bind otg_evt_irq otg_evt_irq_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lpm_i(lpm_i), .reg_rd_i(reg_rd_i),
  .reg_addr_i(reg_addr_i), .rxcmd_req_o(rxcmd_req_o), .rxcmd_alt_o(rxcmd_alt_o),
  .rxcmd_ack_i(rxcmd_ack_i), .evt(src_evt), .alt_evt(alt_evt), .latch(latch_w)
);

// File: tb/otg_evt_irq_test.sv
module otg_evt_irq_test;
  localparam int CLK_NS = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic         bvalid = 1'b0, lpm = 1'b0, ack = 1'b0;
  logic [2:0]   addr = '0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [1:0]   op = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         req, alt;
  int           n_chk = 0, n_err = 0;
  logic [N-1:0] tmp;

  always #(CLK_NS/2) clk = ~clk;

  otg_evt_irq #(.N_SRC(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bvalid_i(bvalid), .lpm_i(lpm),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_op_i(op), .reg_wdata_i(wdata),
    .reg_rd_i(rd), .reg_rdata_o(rdata), .rxcmd_req_o(req), .rxcmd_alt_o(alt),
    .rxcmd_ack_i(ack)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic reg_op(logic [2:0] a, logic [1:0] o, logic [N-1:0] d);
    @(negedge clk); addr = a; op = o; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [N-1:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  // three edges: two sync stages plus edge register
  task automatic set_src(logic [N-1:0] v);
    @(negedge clk); src = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_bv(logic v);
    @(negedge clk); bvalid = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 req", req, 0);
    chk("R1 alt", alt, 0);
    reg_rd(3'd2, tmp); chk("R1 latch", tmp, 0);
    reg_rd(3'd0, tmp); chk("R1 rise_en", tmp, 0);
    reg_rd(3'd1, tmp); chk("R1 fall_en", tmp, 0);
    reg_rd(3'd3, tmp); chk("R1 alt_en", tmp, 0);
  endtask

  task automatic t_reg_ops();
    reg_op(3'd0, 2'b00, 4'b0101); reg_rd(3'd0, tmp); chk("R8 write", tmp, 4'b0101);
    reg_op(3'd0, 2'b01, 4'b0010); reg_rd(3'd0, tmp); chk("R8 set", tmp, 4'b0111);
    reg_op(3'd0, 2'b10, 4'b0100); reg_rd(3'd0, tmp); chk("R8 clear", tmp, 4'b0011);
    reg_op(3'd0, 2'b11, 4'b1111); reg_rd(3'd0, tmp); chk("R8 noop", tmp, 4'b0011);
    reg_op(3'd2, 2'b00, 4'b1111); reg_rd(3'd2, tmp); chk("R8 latch ro", tmp, 0);
    reg_op(3'd1, 2'b00, 4'b1001); reg_rd(3'd1, tmp); chk("R8 fall_en", tmp, 4'b1001);
    reg_op(3'd1, 2'b00, 4'b0001);
  endtask

  task automatic t_rise();
    set_src(4'b0001);
    chk("R9 req on rise", req, 1);
    reg_rd(3'd4, tmp); chk("R8 status", tmp, 4'b0001);
    reg_rd(3'd2, tmp); chk("R2 rise latch", tmp, 4'b0001);
    reg_rd(3'd2, tmp); chk("R5 read clears", tmp, 0);
    do_ack(); chk("R9 ack drops", req, 0);
  endtask

  task automatic t_fall();
    set_src(4'b0000);
    chk("R9 req on fall", req, 1);
    reg_rd(3'd2, tmp); chk("R3 fall latch", tmp, 4'b0001);
    do_ack();
  endtask

  task automatic t_masked();
    set_src(4'b1000);
    chk("R4 rise masked req", req, 0);
    reg_rd(3'd2, tmp); chk("R4 rise masked latch", tmp, 0);
    set_src(4'b0000);
    chk("R4 fall masked req", req, 0);
    reg_rd(3'd2, tmp); chk("R4 fall masked latch", tmp, 0);
  endtask

  task automatic t_merge();
    set_src(4'b0001);
    set_src(4'b0011);
    chk("R9 merged req", req, 1);
    do_ack(); chk("R9 one ack clears merged", req, 0);
    reg_rd(3'd2, tmp); chk("R2 two bits", tmp, 4'b0011);
  endtask

  task automatic t_collide();
    set_src(4'b0010);            // bit0 falls, fall_en=0001
    reg_rd(3'd2, tmp);           // drain
    do_ack();
    set_src(4'b0000);            // bit1 falls, masked
    set_src(4'b0001);            // bit0 rises
    @(negedge clk); src = 4'b0011;
    repeat (2) @(posedge clk);
    @(negedge clk); addr = 3'd2; rd = 1'b1; ack = 1'b1;
    @(negedge clk); rd = 1'b0; ack = 1'b0;
    chk("R6 read returns old", rdata, 4'b0001);
    chk("R12 req kept", req, 1);
    reg_rd(3'd2, tmp); chk("R6 new bit kept", tmp, 4'b0010);
    do_ack();
  endtask

  task automatic t_lpm();
    set_src(4'b0010);            // bit0 falls
    @(negedge clk); lpm = 1'b1;
    @(negedge clk);
    reg_rd(3'd2, tmp); chk("R7 lpm clears", tmp, 0);
    @(negedge clk); lpm = 1'b0;
    do_ack();
  endtask

  task automatic t_alt();
    set_bv(1'b1); set_bv(1'b0);
    chk("R11 alt disabled", req, 0);
    reg_op(3'd3, 2'b01, 4'b0001);
    reg_rd(3'd3, tmp); chk("R8 alt_en", tmp, 4'b0001);
    set_bv(1'b1);
    chk("R11 bvalid rise", req, 0);
    set_bv(1'b0);
    chk("R10 req", req, 1);
    chk("R10 alt", alt, 1);
    reg_rd(3'd2, tmp); chk("R10 latch untouched", tmp, 0);
    do_ack();
    chk("R10 req after ack", req, 0);
    chk("R10 alt after ack", alt, 0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_err++;
    $display("FAIL watchdog got=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_reg_ops();
    t_rise();
    t_fall();
    t_masked();
    t_merge();
    t_collide();
    t_lpm();
    t_alt();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule